// File: doc/BRIEF.md
# Double-Buffered Programming Register Bank

This block is the programming front end of a frequency synthesizer. A host writes bytes over an 8-bit parallel port with a 6-bit address. Each write lands in a shadow byte, not in the register that drives the datapath. Shadow contents move into the active registers all at once, on a commit event. Several bytes that belong together, such as a 48-bit tuning word, therefore always reach the datapath as one consistent value.

A commit comes from one of two sources, chosen by a control bit in the active bank. In internal mode a down-counter reloads from a programmed period and commits each time it reaches zero. It also drives the bidirectional update pin as an output, raising it for a fixed number of cycles to mark each commit. In external mode the pin is an input: it passes through a two-flop synchronizer, and each rising edge commits. Reads always return the active bank. A one-cycle reset pulse is stretched so that the block stays in reset for a fixed number of cycles, and leaves it in single-tone mode with both tuning words at zero and internal update selected.

Top module: `dbuf_regbank`

## Requirements
- R1: Writes change only shadow bytes. The tuning word, phase and mode outputs change only on the clock edge that applies a commit.
- R2: Map, with the highest-order byte at the lowest address. Phase A is at 0x00–0x01 and phase B at 0x02–0x03; each is 14 bits, and only bits 5:0 of the upper byte (0x00 or 0x02) are kept. Tuning word A is at 0x04–0x09 and tuning word B at 0x0A–0x0F. The update period is 16 bits at 0x1A–0x1B. The control byte is at 0x1F: bit 0 = 1 selects internal update, bits 3:1 hold the mode, and bits 7:4 are kept at 0. Writes to any other address are ignored, and reads of them return 0.
- R3: In internal mode the timer commits once every P+1 cycles, where P is the active period value.
- R4: In internal mode, upd_out goes high for exactly 8 cycles on each commit. The active registers change on the clock edge that follows the rise of upd_out.
- R5: In external mode, upd_oe and upd_out are low and the timer makes no commit. A rising level on upd_in is seen by the third rising clock edge after it, and that edge updates the outputs. Holding upd_in high causes no further commit.
- R6: A read with rd_en returns the active byte on rdata one cycle later, with rvalid high.
- R7: A one-cycle rst holds the block in reset for 10 cycles, and writes made during that time are ignored. After reset, every byte is 0 except the control byte, which is 0x01, and the period, which equals PERIOD_DEF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high master reset |
| wr_en | input | 1 | Write strobe for the shadow byte at addr |
| rd_en | input | 1 | Read strobe for the active byte at addr |
| addr | input | 6 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rvalid | output | 1 | rdata valid |
| upd_in | input | 1 | Update pin, input side (asynchronous) |
| upd_out | output | 1 | Update pin, output side |
| upd_oe | output | 1 | Update pin drive enable (1 = internal mode) |
| ftw_a | output | 48 | Active tuning word A |
| ftw_b | output | 48 | Active tuning word B |
| phase_a | output | 14 | Active phase A |
| phase_b | output | 14 | Active phase B |
| mode | output | 3 | Active mode field |

## Verification
A corrupted shadow byte stays hidden until the next commit. It then shows as a wrong tuning word or phase value on the edge after the update pulse rises, and it can be read back from then on. A wrong timer count shows as a changed distance between update pulses, which is visible within one period. A fault in the synchronizer or edge detector moves the output change away from the third edge after upd_in rises, or makes held levels commit again. A fault in the reset stretcher lets a write made during reset surface at the first commit after reset.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int ADDR_W    = 6;
  localparam int BYTE_W    = 8;
  localparam int SLOTS     = 32;
  localparam int TW_BYTES  = 6;
  localparam int PER_BYTES = 2;
  localparam int PH_W      = 14;
  localparam int MODE_W    = 3;

  localparam int PHA_BASE  = 0;
  localparam int PHB_BASE  = 2;
  localparam int TWA_BASE  = 4;
  localparam int TWB_BASE  = 10;
  localparam int PER_BASE  = 26;
  localparam int CTRL_SLOT = 31;

  localparam int TMR_W     = PER_BYTES * BYTE_W;

  // Writable bits of each slot; zero means unmapped
  function automatic logic [BYTE_W-1:0] slot_mask(input int idx);
    if (idx == PHA_BASE || idx == PHB_BASE)                   return 8'h3F;
    if (idx == PHA_BASE + 1 || idx == PHB_BASE + 1)           return 8'hFF;
    if (idx >= TWA_BASE && idx < TWB_BASE + TW_BYTES)         return 8'hFF;
    if (idx >= PER_BASE && idx < PER_BASE + PER_BYTES)        return 8'hFF;
    if (idx == CTRL_SLOT)                                     return 8'h0F;
    return 8'h00;
  endfunction

  function automatic logic [BYTE_W-1:0] slot_default(input int idx,
                                                     input logic [TMR_W-1:0] per);
    if (idx == CTRL_SLOT)    return 8'h01;
    if (idx == PER_BASE)     return per[TMR_W-1 -: BYTE_W];
    if (idx == PER_BASE + 1) return per[BYTE_W-1:0];
    return 8'h00;
  endfunction
endpackage

// File: rtl/dbuf_store.sv
module dbuf_store
  import dbuf_pkg::*;
#(
  parameter logic [TMR_W-1:0] PERIOD_DEF = 16'd100
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [BYTE_W-1:0]         wdata,
  input  logic                      commit,
  output logic [SLOTS*BYTE_W-1:0]   act_flat
);
  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    localparam logic [BYTE_W-1:0] MASK = slot_mask(i);
    localparam logic [BYTE_W-1:0] DEF  = slot_default(i, PERIOD_DEF);
    logic [BYTE_W-1:0] shadow_q;
    logic [BYTE_W-1:0] active_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_q <= DEF;
      end else if (wr_en && waddr == ADDR_W'(i)) begin
        shadow_q <= wdata & MASK;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        active_q <= DEF;
      end else if (commit) begin
        active_q <= shadow_q;
      end
    end

    assign act_flat[i*BYTE_W +: BYTE_W] = active_q;
  end
endmodule

// File: rtl/dbuf_ext_sync.sv
module dbuf_ext_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= async_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/dbuf_upd_timer.sv
module dbuf_upd_timer #(
  parameter int TMR_W     = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [TMR_W-1:0] period,
  output logic             fire,
  output logic             pulse
);
  localparam int PC_W = $clog2(PULSE_LEN + 1);

  logic [TMR_W-1:0] count_q;
  logic [PC_W-1:0]  pcnt_q;
  logic             pulse_q, fire_q;
  logic             at_zero;

  assign at_zero = (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      count_q <= period;
      fire_q  <= 1'b0;
      pcnt_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      fire_q  <= at_zero;
      count_q <= at_zero ? period : count_q - 1'b1;
      if (at_zero) begin
        pcnt_q  <= PC_W'(PULSE_LEN - 1);
        pulse_q <= 1'b1;
      end else if (pcnt_q != '0) begin
        pcnt_q  <= pcnt_q - 1'b1;
        pulse_q <= 1'b1;
      end else begin
        pulse_q <= 1'b0;
      end
    end
  end

  assign fire  = fire_q & en;
  assign pulse = pulse_q & en;
endmodule

// File: rtl/dbuf_regbank.sv
module dbuf_regbank
  import dbuf_pkg::*;
#(
  parameter logic [TMR_W-1:0] PERIOD_DEF = 16'd100,
  parameter int               PULSE_LEN  = 8,
  parameter int               RST_LEN    = 10
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [BYTE_W-1:0]      wdata,
  output logic [BYTE_W-1:0]      rdata,
  output logic                   rvalid,
  input  logic                   upd_in,
  output logic                   upd_out,
  output logic                   upd_oe,
  output logic [TW_BYTES*8-1:0]  ftw_a,
  output logic [TW_BYTES*8-1:0]  ftw_b,
  output logic [PH_W-1:0]        phase_a,
  output logic [PH_W-1:0]        phase_b,
  output logic [MODE_W-1:0]      mode
);
  localparam int RC_W  = $clog2(RST_LEN);
  localparam int HI6   = PH_W - BYTE_W;

  logic [RC_W-1:0]             rst_cnt_q;
  logic                        rst_int;
  logic [SLOTS*BYTE_W-1:0]     act_flat;
  logic                        int_mode, commit, tmr_fire, ext_rise;
  logic [TMR_W-1:0]            period;

  // Reset stretcher: total hold of RST_LEN cycles
  always_ff @(posedge clk) begin
    if (rst) begin
      rst_cnt_q <= RC_W'(RST_LEN - 1);
    end else if (rst_cnt_q != '0) begin
      rst_cnt_q <= rst_cnt_q - 1'b1;
    end
  end
  assign rst_int = rst | (rst_cnt_q != '0);

  dbuf_store #(.PERIOD_DEF(PERIOD_DEF)) store_i (
    .clk(clk), .rst(rst_int), .wr_en(wr_en), .waddr(addr), .wdata(wdata),
    .commit(commit), .act_flat(act_flat)
  );

  dbuf_ext_sync sync_i (
    .clk(clk), .rst(rst_int), .async_in(upd_in), .rise(ext_rise)
  );

  dbuf_upd_timer #(.TMR_W(TMR_W), .PULSE_LEN(PULSE_LEN)) timer_i (
    .clk(clk), .rst(rst_int), .en(int_mode), .period(period),
    .fire(tmr_fire), .pulse(upd_out)
  );

  assign int_mode = act_flat[CTRL_SLOT*BYTE_W];
  assign mode     = act_flat[CTRL_SLOT*BYTE_W + 1 +: MODE_W];
  assign commit   = int_mode ? tmr_fire : ext_rise;
  assign upd_oe   = int_mode;

  for (genvar b = 0; b < PER_BYTES; b++) begin : g_per
    assign period[(PER_BYTES-1-b)*BYTE_W +: BYTE_W] = act_flat[(PER_BASE+b)*BYTE_W +: BYTE_W];
  end

  for (genvar b = 0; b < TW_BYTES; b++) begin : g_tw
    assign ftw_a[(TW_BYTES-1-b)*BYTE_W +: BYTE_W] = act_flat[(TWA_BASE+b)*BYTE_W +: BYTE_W];
    assign ftw_b[(TW_BYTES-1-b)*BYTE_W +: BYTE_W] = act_flat[(TWB_BASE+b)*BYTE_W +: BYTE_W];
  end

  assign phase_a = {act_flat[PHA_BASE*BYTE_W +: HI6], act_flat[(PHA_BASE+1)*BYTE_W +: BYTE_W]};
  assign phase_b = {act_flat[PHB_BASE*BYTE_W +: HI6], act_flat[(PHB_BASE+1)*BYTE_W +: BYTE_W]};

  // Read port returns the active bank
  always_ff @(posedge clk) begin
    if (rst_int) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= (int'(addr) < SLOTS) ? act_flat[int'(addr)*BYTE_W +: BYTE_W] : '0;
      end
    end
  end
endmodule

// File: rtl/dbuf_regbank_chk.sv
module dbuf_regbank_chk #(
  parameter int PULSE_LEN = 8,
  parameter int RST_LEN   = 10
) (
  input logic        clk,
  input logic        rst,
  input logic        rst_int,
  input logic        int_mode,
  input logic        commit,
  input logic        upd_out,
  input logic        upd_oe,
  input logic        rd_en,
  input logic        rvalid,
  input logic [47:0] ftw_a,
  input logic [47:0] ftw_b,
  input logic [2:0]  mode
);
  logic [15:0] hi_cnt_q;
  logic [15:0] rst_cnt_q;

  always_ff @(posedge clk) begin
    if (rst_int || !upd_out) hi_cnt_q <= '0;
    else if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rst_cnt_q <= 16'd1;
    else if (!rst_int) rst_cnt_q <= '0;
    else if (rst_cnt_q != 16'hFFFF) rst_cnt_q <= rst_cnt_q + 1'b1;
  end

  assert_hold_until_commit_R1: assert property (@(posedge clk) disable iff (rst_int)
    (!$stable(ftw_a) || !$stable(ftw_b) || !$stable(mode)) |-> $past(commit));

  assert_pulse_marks_commit_R4: assert property (@(posedge clk) disable iff (rst_int)
    $rose(upd_out) |-> commit);

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (rst_int)
    ($fell(upd_out) && int_mode) |-> (hi_cnt_q >= 16'(PULSE_LEN)));

  assert_ext_pin_quiet_R5: assert property (@(posedge clk) disable iff (rst_int)
    !upd_oe |-> !upd_out);

  assert_read_valid_R6: assert property (@(posedge clk) disable iff (rst_int)
    rd_en |=> rvalid);

  assert_reset_length_R7: assert property (@(posedge clk)
    $fell(rst_int) |-> (rst_cnt_q >= 16'(RST_LEN)));
endmodule

bind dbuf_regbank dbuf_regbank_chk #(.PULSE_LEN(PULSE_LEN), .RST_LEN(RST_LEN)) chk_i (
  .clk(clk), .rst(rst), .rst_int(rst_int), .int_mode(int_mode), .commit(commit),
  .upd_out(upd_out), .upd_oe(upd_oe), .rd_en(rd_en), .rvalid(rvalid),
  .ftw_a(ftw_a), .ftw_b(ftw_b), .mode(mode)
);

// File: tb/dbuf_regbank_tb_top.sv
module dbuf_regbank_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, upd_in = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        rvalid, upd_out, upd_oe;
  logic [47:0] ftw_a, ftw_b;
  logic [13:0] phase_a, phase_b;
  logic [2:0]  mode;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #2.5 clk = ~clk;

  dbuf_regbank dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid), .upd_in(upd_in), .upd_out(upd_out), .upd_oe(upd_oe),
    .ftw_a(ftw_a), .ftw_b(ftw_b), .phase_a(phase_a), .phase_b(phase_b), .mode(mode)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_tw(input logic [5:0] base, input logic [47:0] v);
    for (int b = 0; b < 6; b++) wr(base + 6'(b), v[(5-b)*8 +: 8]);
  endtask

  // Driver: push the expected byte, issue the read
  task automatic rd(input logic [5:0] a, input logic [7:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk); rd_en = 1'b1; addr = a; sb_q.push_back(it);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // Monitor: compare read results as they come out
  always @(negedge clk) begin
    if (rvalid) begin
      if (sb_q.size() == 0) check("R6 unexpected rvalid", 1, 0);
      else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.tag, {56'd0, rdata}, {56'd0, it.exp});
      end
    end
  end

  // Returns at the first negedge where upd_out is seen high after being low
  task automatic wait_upd(input string tag);
    int n = 0;
    while (upd_out === 1'b1 && n < 2000) begin @(negedge clk); n++; end
    while (upd_out !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    if (n >= 2000) check({tag, " update pulse timeout"}, 0, 1);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      check("watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int width;
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (12) @(negedge clk);

    // Reset state
    check("R7 ftw_a default", ftw_a, 0);
    check("R7 ftw_b default", ftw_b, 0);
    check("R7 mode default", mode, 0);
    check("R7 internal update default", upd_oe, 1);
    rd(6'h1F, 8'h01, "R7 control default");
    rd(6'h1A, 8'h00, "R7 period high default");
    rd(6'h1B, 8'd100, "R7 period low default");

    // Stage values in the shadow bytes
    wr_tw(6'h04, 48'h1234_5678_9ABC);
    wr(6'h1A, 8'h00);
    wr(6'h1B, 8'd30);
    wr(6'h00, 8'hFF);
    wr(6'h01, 8'h11);
    wr(6'h20, 8'h77);
    check("R1 ftw_a unchanged before commit", ftw_a, 0);
    rd(6'h04, 8'h00, "R6 read returns active not shadow");

    // First internal commit
    wait_upd("R4");
    check("R4 outputs old while pulse rises", ftw_a, 0);
    width = 1;
    @(negedge clk);
    check("R4 ftw_a updated one cycle after pulse", ftw_a, 48'h1234_5678_9ABC);
    check("R2 phase_a masked upper byte", phase_a, 14'h3F11);
    while (upd_out === 1'b1 && width < 100) begin width++; @(negedge clk); end
    check("R4 pulse width", width, 8);
    rd(6'h00, 8'h3F, "R2 phase upper byte reads masked");
    rd(6'h20, 8'h00, "R2 unmapped address reads 0");
    rd(6'h09, 8'hBC, "R2 lowest byte at highest address");

    // Timer interval with period 30
    wait_upd("R3");
    gap = 0;
    do begin @(negedge clk); gap++; end while (!(upd_out === 1'b1 && gap > 10) && gap < 500);
    check("R3 commit interval", gap, 31);

    // Switch to external mode with mode field 3
    wr(6'h1F, 8'h06);
    wait_upd("R5 switch");
    @(negedge clk);
    check("R5 pin released in external mode", upd_oe, 0);
    check("R2 mode field", mode, 3);
    wr_tw(6'h0A, 48'hA5A5_0F0F_3C3C);
    repeat (40) @(negedge clk);
    check("R5 no timer commit in external mode", ftw_b, 0);
    check("R5 upd_out low in external mode", upd_out, 0);

    @(negedge clk); upd_in = 1'b1;
    @(negedge clk); check("R5 edge 1 no change", ftw_b, 0);
    @(negedge clk); check("R5 edge 2 no change", ftw_b, 0);
    @(negedge clk); check("R5 edge 3 commit", ftw_b, 48'hA5A5_0F0F_3C3C);
    wr_tw(6'h0A, 48'h1111_1111_1111);
    repeat (10) @(negedge clk);
    check("R5 held level no commit", ftw_b, 48'hA5A5_0F0F_3C3C);
    rd(6'h0A, 8'hA5, "R6 read active after external commit");
    upd_in = 1'b0;
    repeat (4) @(negedge clk);
    upd_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 second edge commit", ftw_b, 48'h1111_1111_1111);

    // Back to internal
    wr(6'h1F, 8'h01);
    upd_in = 1'b0;
    repeat (4) @(negedge clk);
    upd_in = 1'b1;
    repeat (4) @(negedge clk);
    check("R5 external commit restores internal", upd_oe, 1);
    upd_in = 1'b0;

    // Master reset with a write during the stretched reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    repeat (2) @(negedge clk);
    wr(6'h09, 8'h55);
    repeat (10) @(negedge clk);
    check("R7 ftw_a after reset", ftw_a, 0);
    check("R7 ftw_b after reset", ftw_b, 0);
    check("R7 mode after reset", mode, 0);
    check("R7 internal after reset", upd_oe, 1);
    rd(6'h1B, 8'd100, "R7 period restored");
    wait_upd("R7");
    @(negedge clk);
    check("R7 write during reset ignored", ftw_a, 0);

    repeat (4) @(negedge clk);
    check("R6 scoreboard drained", sb_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule